// File: doc/BRIEF.md
# NAND Cache-Read Burst Sequencer

This block sits on the host side of a raw 8-bit NAND flash bus and reads a run of consecutive pages with the device's cache pipeline. One request carries a start row, a page count, a column (which must be zero) and a flag that selects four or five address cycles. The block opens the burst with a read-setup command, the address cycles and the cache-read confirm. It waits out the initial busy period on Ready/Busy and then streams every byte of every page to a valid/ready output port.

Between pages the block reads the status register until the device reports that the cache register holds the next page. It then returns the device to data-output mode and continues. After the last page it polls until the internal array read has finished, so that no page is lost. It then sends the exit command and waits for Ready/Busy before it signals completion. Every strobe phase is counted in whole clock cycles from parameters. A watchdog aborts the burst if Ready/Busy stays low too long.

Top module: `nand_cache_rd_seq`

## Requirements
- R1: A request accepted with a nonzero column is rejected: `err_col_o` pulses for one cycle in the next cycle, no bus cycle is issued, and `req_ready_o` stays high.
- R2: A valid request produces, in order: command 00h, the address cycles (column low byte 00h, column high byte 00h, then row bits 7:0 and 15:8, plus row bits 23:16 only when `req_five_cyc_i` is 1), then command 31h. Command cycles have CLE high, and address cycles have ALE high.
- R3: In every command or address cycle, the latch strobe is high and the I/O bus is driven for at least one cycle before write-enable falls. Write-enable stays low for T_PULSE cycles, and the latch strobe is still high in the cycle after write-enable rises. CLE and ALE are never high together, and write-enable and read-enable are never low together.
- R4: After the confirm command, the block waits T_WB cycles and then until Ready/Busy is high. It issues no bus cycle while it waits.
- R5: The block delivers exactly PAGE_BYTES bytes per requested page, in device order, on `dout_*`. While `dout_valid_o` is high and `dout_ready_i` is low, the byte is held unchanged.
- R6: Before each page after the first, the block issues 70h and reads status bytes until bit 6 is 1. It then issues 00h and resumes reading data without any new address. No data byte is read while bit 6 is 0.
- R7: After the last page, the block reads status until bit 5 is 1, issues 34h, waits T_WB cycles and then until Ready/Busy is high, and pulses `done_o` for one cycle.
- R8: If Ready/Busy stays low for WDOG_LIMIT consecutive cycles in a busy wait, `err_timeout_o` pulses and the block returns to idle.
- R9: `req_ready_o` is high only when idle. While idle, CLE and ALE are low and both enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Burst request valid |
| req_ready_o | output | 1 | Idle, request accepted |
| req_row_i | input | 24 | Start page row address |
| req_col_i | input | 16 | Start column, must be zero |
| req_five_cyc_i | input | 1 | 1: five address cycles, 0: four |
| req_pages_i | input | 16 | Number of pages, at least 1 |
| done_o | output | 1 | Burst completed pulse |
| err_col_o | output | 1 | Nonzero column rejection pulse |
| err_timeout_o | output | 1 | Ready/Busy timeout pulse |
| dout_valid_o | output | 1 | Data byte valid |
| dout_ready_i | input | 1 | Data byte accepted |
| dout_data_o | output | 8 | Page data byte |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write enable, active low |
| nand_re_no | output | 1 | Read enable, active low |
| nand_io_o | output | 8 | I/O bus output value |
| nand_io_oe_o | output | 1 | I/O bus output enable |
| nand_io_i | input | 8 | I/O bus input value |
| nand_rb_i | input | 1 | Ready/Busy, low while busy |

## Verification
The assertions check the following on every cycle: strobe exclusivity, setup and hold around each write-enable pulse, a quiet bus while idle and during the post-confirm wait, stable held output data, the one-cycle column rejection, and that a timeout only follows a low Ready/Busy. The bench's scenarios are the only way to show the rest. These are the exact command and address order for both address widths, the byte order across page boundaries, and that the status polling really stalls on bits 6 and 5. A device model that delays those bits and flags any early read or early exit supplies that evidence. The model also holds Ready/Busy low to force a watchdog abort.

// File: rtl/nand_crd_pkg.sv
package nand_crd_pkg;
  localparam int ROW_W = 24;
  localparam int COL_W = 16;

  localparam logic [7:0] OPC_READ   = 8'h00;
  localparam logic [7:0] OPC_CACHE  = 8'h31;
  localparam logic [7:0] OPC_STATUS = 8'h70;
  localparam logic [7:0] OPC_EXIT   = 8'h34;

  localparam int SR_ARRAY_DONE = 5;
  localparam int SR_CACHE_RDY  = 6;

  typedef enum logic [1:0] {OP_CMD, OP_ADDR, OP_READ} bus_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP_CMD, S_ADDR, S_CONFIRM, S_WB, S_BUSY, S_DATA,
    S_SR_CMD, S_SR_READ, S_RESUME, S_EXIT_CMD, S_EXIT_WB, S_EXIT_BUSY
  } seq_state_e;
endpackage

// File: rtl/nand_crd_bus.sv
module nand_crd_bus
  import nand_crd_pkg::*;
#(
  parameter int T_SETUP = 1,
  parameter int T_PULSE = 2,
  parameter int T_HOLD  = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  bus_op_e    op_i,
  input  logic [7:0] wdata_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rdata_o,
  output logic       cle_o,
  output logic       ale_o,
  output logic       we_no,
  output logic       re_no,
  output logic [7:0] io_o,
  output logic       io_oe_o,
  input  logic [7:0] io_i
);
  localparam int TMAX = (T_SETUP > T_PULSE) ? ((T_SETUP > T_HOLD) ? T_SETUP : T_HOLD)
                                            : ((T_PULSE > T_HOLD) ? T_PULSE : T_HOLD);
  localparam int CW = (TMAX < 2) ? 1 : $clog2(TMAX);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD} phase_e;

  phase_e     phase;
  bus_op_e    op_q;
  logic [7:0] wd_q;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase <= PH_IDLE; op_q <= OP_CMD; wd_q <= '0; cnt <= '0;
      done_o <= 1'b0; rdata_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (phase)
        PH_IDLE: if (start_i) begin
          op_q  <= op_i;
          wd_q  <= wdata_i;
          cnt   <= '0;
          phase <= (op_i == OP_READ) ? PH_PULSE : PH_SETUP;
        end
        PH_SETUP: if (cnt == CW'(T_SETUP-1)) begin
          phase <= PH_PULSE; cnt <= '0;
        end else cnt <= cnt + 1'b1;
        PH_PULSE: if (cnt == CW'(T_PULSE-1)) begin
          if (op_q == OP_READ) rdata_o <= io_i;
          phase <= PH_HOLD; cnt <= '0;
        end else cnt <= cnt + 1'b1;
        default: if (cnt == CW'(T_HOLD-1)) begin
          phase <= PH_IDLE; cnt <= '0; done_o <= 1'b1;
        end else cnt <= cnt + 1'b1;
      endcase
    end
  end

  logic active, is_wr;
  assign active  = (phase != PH_IDLE);
  assign is_wr   = (op_q != OP_READ);
  assign busy_o  = active;
  assign cle_o   = active && (op_q == OP_CMD);
  assign ale_o   = active && (op_q == OP_ADDR);
  assign we_no   = !((phase == PH_PULSE) && is_wr);
  assign re_no   = !((phase == PH_PULSE) && !is_wr);
  assign io_oe_o = active && is_wr;
  assign io_o    = wd_q;

  a_r3_enables_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !re_no));
  a_r3_latch_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));
  a_r3_setup_before_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_no) |-> $past(cle_o || ale_o) && $past(io_oe_o));
  a_r3_hold_after_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_no) |-> (cle_o || ale_o) && io_oe_o);
  a_r3_no_drive_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_no |-> !io_oe_o);
endmodule

// File: rtl/nand_crd_wdog.sv
module nand_crd_wdog #(
  parameter int LIMIT = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic rb_i,
  output logic timeout_o
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt <= '0; timeout_o <= 1'b0;
    end else begin
      timeout_o <= 1'b0;
      if (!en_i || rb_i) cnt <= '0;
      else if (cnt == CW'(LIMIT-1)) begin
        cnt <= '0; timeout_o <= 1'b1;
      end else cnt <= cnt + 1'b1;
    end
  end

  a_r8_timeout_needs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> $past(en_i && !rb_i));
endmodule

// File: rtl/nand_cache_rd_seq.sv
module nand_cache_rd_seq
  import nand_crd_pkg::*;
#(
  parameter int PAGE_BYTES = 2112,
  parameter int T_SETUP    = 1,
  parameter int T_PULSE    = 2,
  parameter int T_HOLD     = 1,
  parameter int T_WB       = 4,
  parameter int WDOG_LIMIT = 100000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic [COL_W-1:0] req_col_i,
  input  logic             req_five_cyc_i,
  input  logic [15:0]      req_pages_i,
  output logic             done_o,
  output logic             err_col_o,
  output logic             err_timeout_o,
  output logic             dout_valid_o,
  input  logic             dout_ready_i,
  output logic [7:0]       dout_data_o,
  output logic             nand_cle_o,
  output logic             nand_ale_o,
  output logic             nand_we_no,
  output logic             nand_re_no,
  output logic [7:0]       nand_io_o,
  output logic             nand_io_oe_o,
  input  logic [7:0]       nand_io_i,
  input  logic             nand_rb_i
);
  localparam int BCW = (PAGE_BYTES < 2) ? 1 : $clog2(PAGE_BYTES);
  localparam int WCW = $clog2(T_WB + 1);

  seq_state_e       state;
  logic [ROW_W-1:0] row_q;
  logic             five_q;
  logic [15:0]      pages_left;
  logic [BCW-1:0]   byte_cnt;
  logic [2:0]       addr_idx;
  logic [WCW-1:0]   wb_cnt;
  logic             final_poll;
  logic [1:0]       rb_sync;
  logic             rb_s;

  // Ready/Busy is asynchronous to the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rb_sync <= 2'b11;
    else         rb_sync <= {rb_sync[0], nand_rb_i};
  end
  assign rb_s = rb_sync[1];

  logic       bus_start, bus_busy, bus_done, bus_req;
  bus_op_e    bus_op;
  logic [7:0] bus_wdata, bus_rdata, addr_byte;
  logic       wd_timeout;

  always_comb begin
    case (addr_idx)
      3'd2:    addr_byte = row_q[7:0];
      3'd3:    addr_byte = row_q[15:8];
      3'd4:    addr_byte = row_q[23:16];
      default: addr_byte = 8'h00;
    endcase
  end

  always_comb begin
    bus_req   = 1'b1;
    bus_op    = OP_CMD;
    bus_wdata = OPC_READ;
    case (state)
      S_SETUP_CMD: bus_wdata = OPC_READ;
      S_ADDR:      begin bus_op = OP_ADDR; bus_wdata = addr_byte; end
      S_CONFIRM:   bus_wdata = OPC_CACHE;
      S_SR_CMD:    bus_wdata = OPC_STATUS;
      S_SR_READ:   bus_op = OP_READ;
      S_RESUME:    bus_wdata = OPC_READ;
      S_EXIT_CMD:  bus_wdata = OPC_EXIT;
      S_DATA:      begin bus_op = OP_READ; bus_req = !dout_valid_o; end
      default:     bus_req = 1'b0;
    endcase
  end
  assign bus_start = bus_req && !bus_busy && !bus_done;

  nand_crd_bus #(.T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD)) u_bus (
    .clk_i, .rst_ni,
    .start_i (bus_start),
    .op_i    (bus_op),
    .wdata_i (bus_wdata),
    .busy_o  (bus_busy),
    .done_o  (bus_done),
    .rdata_o (bus_rdata),
    .cle_o   (nand_cle_o),
    .ale_o   (nand_ale_o),
    .we_no   (nand_we_no),
    .re_no   (nand_re_no),
    .io_o    (nand_io_o),
    .io_oe_o (nand_io_oe_o),
    .io_i    (nand_io_i)
  );

  nand_crd_wdog #(.LIMIT(WDOG_LIMIT)) u_wdog (
    .clk_i, .rst_ni,
    .en_i      ((state == S_BUSY) || (state == S_EXIT_BUSY)),
    .rb_i      (rb_s),
    .timeout_o (wd_timeout)
  );

  assign req_ready_o = (state == S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= S_IDLE; row_q <= '0; five_q <= 1'b0; pages_left <= '0;
      byte_cnt <= '0; addr_idx <= '0; wb_cnt <= '0; final_poll <= 1'b0;
      done_o <= 1'b0; err_col_o <= 1'b0; err_timeout_o <= 1'b0;
      dout_valid_o <= 1'b0; dout_data_o <= '0;
    end else begin
      done_o <= 1'b0; err_col_o <= 1'b0; err_timeout_o <= 1'b0;
      if (dout_valid_o && dout_ready_i) dout_valid_o <= 1'b0;
      case (state)
        S_IDLE: if (req_valid_i) begin
          if (req_col_i != '0) err_col_o <= 1'b1;
          else begin
            row_q <= req_row_i; five_q <= req_five_cyc_i;
            pages_left <= req_pages_i; addr_idx <= '0;
            state <= S_SETUP_CMD;
          end
        end
        S_SETUP_CMD: if (bus_done) state <= S_ADDR;
        S_ADDR: if (bus_done) begin
          if (addr_idx == (five_q ? 3'd4 : 3'd3)) state <= S_CONFIRM;
          addr_idx <= addr_idx + 1'b1;
        end
        S_CONFIRM: if (bus_done) begin state <= S_WB; wb_cnt <= '0; end
        S_WB, S_EXIT_WB: begin
          if (wb_cnt == WCW'(T_WB)) state <= (state == S_WB) ? S_BUSY : S_EXIT_BUSY;
          else wb_cnt <= wb_cnt + 1'b1;
        end
        S_BUSY, S_EXIT_BUSY: begin
          if (wd_timeout) begin
            err_timeout_o <= 1'b1; state <= S_IDLE;
          end else if (rb_s) begin
            if (state == S_BUSY) begin state <= S_DATA; byte_cnt <= '0; end
            else begin state <= S_IDLE; done_o <= 1'b1; end
          end
        end
        S_DATA: if (bus_done) begin
          dout_valid_o <= 1'b1;
          dout_data_o  <= bus_rdata;
          if (byte_cnt == BCW'(PAGE_BYTES-1)) begin
            byte_cnt   <= '0;
            pages_left <= pages_left - 1'b1;
            final_poll <= (pages_left == 16'd1);
            state      <= S_SR_CMD;
          end else byte_cnt <= byte_cnt + 1'b1;
        end
        S_SR_CMD: if (bus_done) state <= S_SR_READ;
        S_SR_READ: if (bus_done) begin
          // stay and re-read status until the relevant bit is set
          if (final_poll) begin
            if (bus_rdata[SR_ARRAY_DONE]) state <= S_EXIT_CMD;
          end else if (bus_rdata[SR_CACHE_RDY]) state <= S_RESUME;
        end
        S_RESUME: if (bus_done) state <= S_DATA;
        S_EXIT_CMD: if (bus_done) begin state <= S_EXIT_WB; wb_cnt <= '0; end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r1_reject_col: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && (req_col_i != '0) |=> err_col_o && req_ready_o);
  a_r5_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_valid_o && !dout_ready_i |=> dout_valid_o && $stable(dout_data_o));
  a_r4_quiet_in_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_BUSY) || (state == S_WB) |-> nand_re_no && nand_we_no && !nand_io_oe_o);
  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> nand_we_no && nand_re_no && !nand_cle_o && !nand_ale_o);
  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && req_ready_o);
endmodule

// File: tb/nand_cache_rd_seq_tb.sv
module nand_cache_rd_seq_tb;
  localparam int PB = 8;
  localparam int TP = 2;
  localparam int WDL = 300;
  localparam int LAT = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid = 1'b0, req_ready, five = 1'b0;
  logic [23:0] row = '0;
  logic [15:0] col = '0, pages = '0;
  logic done, err_col, err_to, dv, dr = 1'b1;
  logic [7:0] dd, io_o, io_i;
  logic cle, ale, we_n, re_n, io_oe, rb;

  nand_cache_rd_seq #(.PAGE_BYTES(PB), .T_PULSE(TP), .T_WB(3), .WDOG_LIMIT(WDL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_row_i(row), .req_col_i(col), .req_five_cyc_i(five), .req_pages_i(pages),
    .done_o(done), .err_col_o(err_col), .err_timeout_o(err_to),
    .dout_valid_o(dv), .dout_ready_i(dr), .dout_data_o(dd),
    .nand_cle_o(cle), .nand_ale_o(ale), .nand_we_no(we_n), .nand_re_no(re_n),
    .nand_io_o(io_o), .nand_io_oe_o(io_oe), .nand_io_i(io_i), .nand_rb_i(rb));

  function automatic logic [7:0] pat(int p, int b);
    return 8'(p * 37 + b * 5 + 1);
  endfunction

  logic [9:0] q_bus[$];
  logic [7:0] q_dat[$];

  // device model
  logic stuck = 1'b0;
  logic we_p = 1'b1, re_p = 1'b1, cle_p = 1'b0, ale_p = 1'b0, oe_p = 1'b0;
  logic m_stat = 1'b0, c_rdy = 1'b0, a_done = 1'b0;
  int m_busy = 0, c_cnt = 0, a_cnt = 0, m_page = 0, m_b = 0, a_idx = 0, we_run = 0;
  logic [23:0] m_row = '0;
  int v_busy = 0, v_cache = 0, v_exit = 0, nr6 = 0, nr5 = 0;
  int bus_cmp = 0, bus_bad = 0;

  assign rb   = (m_busy == 0) && !stuck;
  assign io_i = m_stat ? {1'b1, c_rdy, a_done, 5'b0} : pat(m_page, m_b);

  always @(posedge clk) begin
    we_p <= we_n; re_p <= re_n; cle_p <= cle; ale_p <= ale; oe_p <= io_oe;
    if (m_busy != 0) m_busy <= m_busy - 1;
    if (c_cnt != 0) begin c_cnt <= c_cnt - 1; if (c_cnt == 1) c_rdy <= 1'b1; end
    if (a_cnt != 0) begin a_cnt <= a_cnt - 1; if (a_cnt == 1) a_done <= 1'b1; end
    we_run <= we_n ? 0 : we_run + 1;
    if (!we_n && we_p) begin
      bus_cmp <= bus_cmp + 1;
      if (!((cle_p || ale_p) && oe_p)) begin
        bus_bad <= bus_bad + 1;
        $display("FAIL R3 setup before WE fall: act latch=%b oe=%b exp latch=1 oe=1", cle_p | ale_p, oe_p);
      end
    end
    if (we_n && !we_p) begin
      bus_cmp <= bus_cmp + 2;
      if (we_run != TP) begin
        bus_bad <= bus_bad + 1;
        $display("FAIL R3 WE low width: act %0d exp %0d", we_run, TP);
      end
      if (q_bus.size() == 0) begin
        bus_bad <= bus_bad + 1;
        $display("FAIL R2 unexpected bus cycle: act %b_%b_%h exp none", cle, ale, io_o);
      end else begin
        logic [9:0] e;
        e = q_bus.pop_front();
        if (e != {cle, ale, io_o}) begin
          bus_bad <= bus_bad + 1;
          $display("FAIL R2 bus cycle: act %b_%b_%h exp %b_%b_%h", cle, ale, io_o, e[9], e[8], e[7:0]);
        end
      end
      if (ale) begin
        if (a_idx >= 2) m_row[(a_idx-2)*8 +: 8] <= io_o;
        a_idx <= a_idx + 1;
      end
      if (cle) begin
        case (io_o)
          8'h00: begin m_stat <= 1'b0; a_idx <= 0; end
          8'h31: begin
            m_busy <= LAT; m_page <= int'(m_row); m_b <= 0;
            c_rdy <= 1'b0; c_cnt <= LAT; a_done <= 1'b0; a_cnt <= LAT + 20;
          end
          8'h70: m_stat <= 1'b1;
          8'h34: begin
            if (!a_done) v_exit <= v_exit + 1;
            m_busy <= 8;
          end
          default: ;
        endcase
        if (io_o == 8'h00) m_row <= '0;
      end
    end
    if (re_n && !re_p) begin
      if (m_stat) begin
        if (!c_rdy) nr6 <= nr6 + 1;
        if (!a_done) nr5 <= nr5 + 1;
      end else begin
        if (!c_rdy) v_cache <= v_cache + 1;
        if (!rb) v_busy <= v_busy + 1;
        if (m_b == PB - 1) begin
          m_page <= m_page + 1; m_b <= 0;
          c_rdy <= 1'b0; c_cnt <= 14; a_done <= 1'b0; a_cnt <= 30;
        end else m_b <= m_b + 1;
      end
    end
  end

  // output consumer with stalls
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    dr  <= (cyc % 5) != 2;
  end

  // data monitor
  int dat_cmp = 0, dat_bad = 0;
  always @(negedge clk) begin
    if (rst_n && dv && dr) begin
      dat_cmp <= dat_cmp + 1;
      if (q_dat.size() == 0) begin
        dat_bad <= dat_bad + 1;
        $display("FAIL R5 unexpected byte: act %h exp none", dd);
      end else begin
        logic [7:0] e;
        e = q_dat.pop_front();
        if (e != dd) begin
          dat_bad <= dat_bad + 1;
          $display("FAIL R5 data: act %h exp %h", dd, e);
        end
      end
    end
  end

  int n_cmp = 0, n_bad = 0;
  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act %0h exp %0h", r, act, exp);
    end
  endtask

  task automatic push_cmd(logic [7:0] c); q_bus.push_back({2'b10, c}); endtask
  task automatic push_adr(logic [7:0] a); q_bus.push_back({2'b01, a}); endtask

  task automatic send(logic [23:0] r, logic [15:0] c, logic f, logic [15:0] n);
    @(negedge clk);
    row = r; col = c; five = f; pages = n; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic burst(logic [23:0] r, logic f, int n);
    logic seen;
    int base;
    push_cmd(8'h00); push_adr(8'h00); push_adr(8'h00);
    push_adr(r[7:0]); push_adr(r[15:8]);
    if (f) push_adr(r[23:16]);
    push_cmd(8'h31);
    for (int k = 1; k < n; k++) begin push_cmd(8'h70); push_cmd(8'h00); end
    push_cmd(8'h70); push_cmd(8'h34);
    base = f ? int'(r) : int'(r[15:0]);
    for (int k = 0; k < n; k++)
      for (int b = 0; b < PB; b++) q_dat.push_back(pat(base + k, b));
    send(r, 16'h0, f, 16'(n));
    chk("R9 ready low in burst", 32'(req_ready), 32'd0);
    seen = 1'b0;
    for (int i = 0; i < 6000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    chk("R7 done pulse", 32'(seen), 32'd1);
    repeat (10) @(negedge clk);
    chk("R7 ready after done", 32'(req_ready), 32'd1);
    chk("R2 all bus cycles seen", 32'(q_bus.size()), 32'd0);
    chk("R5 all bytes delivered", 32'(q_dat.size()), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset ready", 32'(req_ready), 32'd1);
    chk("R9 reset strobes", {cle, ale, we_n, re_n, io_oe, dv}, 32'b001100);
    chk("R9 reset flags", {done, err_col, err_to}, 32'd0);

    // R1: nonzero column
    send(24'h000010, 16'h0003, 1'b0, 16'd2);
    chk("R1 err_col pulse", 32'(err_col), 32'd1);
    chk("R1 still ready", 32'(req_ready), 32'd1);
    repeat (20) @(negedge clk);
    chk("R1 no bus activity", {cle, ale, we_n, re_n}, 32'b0011);
    chk("R1 err_col single", 32'(err_col), 32'd0);

    // R2/R5/R6/R7: five-cycle, three pages
    burst(24'h020103, 1'b1, 3);
    chk("R6 poll loop saw bit6 low", 32'(nr6 > 0), 32'd1);
    chk("R7 exit poll saw bit5 low", 32'(nr5 > 0), 32'd1);
    // four-cycle, two pages
    burst(24'h000345, 1'b0, 2);
    // single page
    burst(24'h0A0B0C, 1'b1, 1);

    // R8: stuck busy
    stuck = 1'b1;
    push_cmd(8'h00); push_adr(8'h00); push_adr(8'h00);
    push_adr(8'h21); push_adr(8'h43); push_cmd(8'h31);
    send(24'h004321, 16'h0, 1'b0, 16'd1);
    begin
      logic seen;
      seen = 1'b0;
      for (int i = 0; i < WDL + 200 && !seen; i++) begin
        @(negedge clk);
        if (err_to) seen = 1'b1;
      end
      chk("R8 timeout pulse", 32'(seen), 32'd1);
    end
    @(negedge clk);
    chk("R8 back to idle", 32'(req_ready), 32'd1);
    chk("R8 no data", 32'(dv), 32'd0);
    chk("R8 bus cycles up to confirm", 32'(q_bus.size()), 32'd0);
    stuck = 1'b0;
    repeat (5) @(negedge clk);

    burst(24'h000777, 1'b0, 2);

    chk("R4 no read while busy", 32'(v_busy), 32'd0);
    chk("R6 no read before cache ready", 32'(v_cache), 32'd0);
    chk("R7 no exit before array done", 32'(v_exit), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             n_cmp + bus_cmp + dat_cmp, n_bad + bus_bad + dat_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: act hung exp finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             n_cmp + bus_cmp + dat_cmp + 1, n_bad + bus_bad + dat_bad + 1);
    $finish;
  end
endmodule